// File: doc/BRIEF.md
# Programmable Tick Watchdog

This block is a watchdog that counts down in steps of an external 16 Hz tick enable. Software arms it with one 8-bit control byte. The low two bits pick a resolution R, the next five bits give a multiplier M, and the top bit decides what a timeout does. The interval is M × 4^R ticks. The count restarts from the current control value whenever the control byte is written. It also restarts when the control byte is read, so a periodic read serves as the "kick".

On expiry the block raises a sticky expiry flag. It then does one of two things:
- With the steering bit clear, it emits a single-cycle interrupt pulse.
- With the steering bit set, it emits a single-cycle reset request. In the same cycle it pulses a strobe that tells a neighbouring register to drop one of its bits, and it wipes its own control byte to zero.

Sequencing the system reset that follows is left to the surrounding logic.

Top module: `tick_watchdog`

## Requirements
- R1: After reset the control byte reads 0x00, and the expiry flag, the interrupt pulse, the reset request and the clear strobe are all low.
- R2: Control bits [1:0] hold R and bits [6:2] hold M. After a write of a nonzero interval, the timeout happens on exactly the (M × 4^R)-th tick, and the outputs show it in the cycle after that tick's clock edge.
- R3: The count moves only in cycles where `tick_en` is high. Any number of cycles without a tick brings no timeout.
- R4: A control byte whose multiplier field is zero leaves the watchdog stopped, whatever R and bit 7 hold. This includes 0x00, 0x03 and 0x80.
- R5: With control bit 7 clear, a timeout gives a one-cycle `wdt_irq` pulse. `wdt_rst_req` stays low.
- R6: With control bit 7 set, a timeout gives a one-cycle `wdt_rst_req` and a one-cycle `ext_clr_stb` in the same cycle. The control byte reads 0x00 from that cycle on, and no interrupt pulse is given.
- R7: `wdt_flag` goes high on a timeout and stays high until the control byte is written or read, which clears it.
- R8: A read of the control byte restarts the full interval from the stored value and leaves the stored value unchanged.
- R9: Each arming gives at most one timeout. Once expired, the block gives no more pulses until the next write or read.
- R10: A write takes priority over a read in the same cycle. A write or read in the same cycle as the final tick cancels that timeout and restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | 16 Hz tick enable, one clock wide |
| ctl_wr | input | 1 | Write strobe for the control byte |
| ctl_wdata | input | 8 | Control byte to write |
| ctl_rd | input | 1 | Read strobe for the control byte (restarts the count) |
| ctl_rdata | output | 8 | Current control byte |
| wdt_flag | output | 1 | Sticky expiry flag |
| wdt_irq | output | 1 | One-cycle interrupt pulse on expiry |
| wdt_rst_req | output | 1 | One-cycle reset request on expiry |
| ext_clr_stb | output | 1 | One-cycle strobe to clear the external register bit |

## Verification
The bench goes after off-by-one intervals at both ends: one tick (0x04) and 1984 ticks (0x7F). A decoder that shifted by R instead of 2R, or that fired on the wrong count, would time out early or late there.

It checks that a zero multiplier with a nonzero resolution stays silent. A design that treated only 0x00 as "off" would underflow and fire.

It puts a read or a write on the final tick. A design with the wrong priority would fire while being restarted.

It checks that a steered timeout wipes the control byte and pulses exactly once. It also checks that nothing repeats after expiry, which catches a counter that reloads itself.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int RES_W_DEF = 2;
  localparam int MUL_W_DEF = 5;

  typedef enum logic [1:0] {
    EXP_NONE = 2'd0,
    EXP_IRQ  = 2'd1,
    EXP_RST  = 2'd2
  } exp_kind_e;

  function automatic int ctl_width(input int res_w, input int mul_w);
    return res_w + mul_w + 1;
  endfunction

  function automatic int cnt_width(input int res_w, input int mul_w);
    return mul_w + 2 * ((1 << res_w) - 1);
  endfunction

endpackage

// File: rtl/wdt_interval.sv
module wdt_interval #(
  parameter int RES_W = wdt_pkg::RES_W_DEF,
  parameter int MUL_W = wdt_pkg::MUL_W_DEF,
  localparam int CTL_W = wdt_pkg::ctl_width(RES_W, MUL_W),
  localparam int CNT_W = wdt_pkg::cnt_width(RES_W, MUL_W)
) (
  input  logic [CTL_W-1:0] ctl,
  output logic [CNT_W-1:0] ticks
);

  localparam int N_RES = 1 << RES_W;

  logic [RES_W-1:0] res;
  logic [MUL_W-1:0] mul;
  logic [CNT_W-1:0] cand [N_RES];

  assign res = ctl[RES_W-1:0];
  assign mul = ctl[RES_W +: MUL_W];

  // One candidate per resolution step: multiplier scaled by 4^g.
  for (genvar g = 0; g < N_RES; g++) begin : g_scale
    assign cand[g] = CNT_W'(mul) << (2 * g);
  end

  always_comb begin
    ticks = '0;
    for (int i = 0; i < N_RES; i++) begin
      if (res == RES_W'(i)) ticks = cand[i];
    end
  end

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick_en,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    cnt_en = 1'b0;
    if (load) begin
      cnt_d  = load_val;
      cnt_en = 1'b1;
    end else if (tick_en && (cnt_q != '0)) begin
      cnt_d  = cnt_q - CNT_W'(1);
      cnt_en = 1'b1;
      expire = (cnt_q == CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/wdt_ctlreg.sv
module wdt_ctlreg #(
  parameter int CTL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  input  logic             wipe,
  output logic [CTL_W-1:0] ctl_q
);

  logic [CTL_W-1:0] ctl_d;
  logic             ctl_en;

  always_comb begin
    ctl_d  = ctl_q;
    ctl_en = 1'b0;
    if (wr) begin
      ctl_d  = wdata;
      ctl_en = 1'b1;
    end else if (wipe) begin
      ctl_d  = '0;
      ctl_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_en) begin
      ctl_q <= ctl_d;
    end
  end

endmodule

// File: rtl/wdt_respond.sv
module wdt_respond (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic steer_rst,
  input  logic restart,
  output logic flag,
  output logic irq,
  output logic rst_req,
  output logic clr_stb
);

  import wdt_pkg::*;

  exp_kind_e kind;
  logic      flag_d, irq_d, rst_d, clr_d;
  logic      flag_q, irq_q, rst_q, clr_q;

  always_comb begin
    kind = EXP_NONE;
    if (expire) kind = steer_rst ? EXP_RST : EXP_IRQ;
  end

  always_comb begin
    flag_d = flag_q;
    if (restart)             flag_d = 1'b0;
    else if (kind != EXP_NONE) flag_d = 1'b1;
    irq_d = (kind == EXP_IRQ);
    rst_d = (kind == EXP_RST);
    clr_d = (kind == EXP_RST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      rst_q  <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= irq_d;
      rst_q  <= rst_d;
      clr_q  <= clr_d;
    end
  end

  assign flag    = flag_q;
  assign irq     = irq_q;
  assign rst_req = rst_q;
  assign clr_stb = clr_q;

endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog #(
  parameter int RES_W = wdt_pkg::RES_W_DEF,
  parameter int MUL_W = wdt_pkg::MUL_W_DEF,
  localparam int CTL_W = wdt_pkg::ctl_width(RES_W, MUL_W),
  localparam int CNT_W = wdt_pkg::cnt_width(RES_W, MUL_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             ctl_rd,
  output logic [CTL_W-1:0] ctl_rdata,
  output logic             wdt_flag,
  output logic             wdt_irq,
  output logic             wdt_rst_req,
  output logic             ext_clr_stb
);

  localparam int STEER = CTL_W - 1;

  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta_q, rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  logic [CTL_W-1:0] ctl_q;
  logic [CTL_W-1:0] ctl_src;
  logic [CNT_W-1:0] interval;
  logic             restart;
  logic             expire;
  logic             wipe;

  assign restart = ctl_wr | ctl_rd;
  assign ctl_src = ctl_wr ? ctl_wdata : ctl_q;
  assign wipe    = expire & ctl_q[STEER];

  wdt_interval #(.RES_W(RES_W), .MUL_W(MUL_W)) u_interval (
    .ctl   (ctl_src),
    .ticks (interval)
  );

  wdt_countdown #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (restart),
    .load_val (interval),
    .tick_en  (tick_en),
    .expire   (expire)
  );

  wdt_ctlreg #(.CTL_W(CTL_W)) u_ctl (
    .clk   (clk),
    .rst_n (rst_core_n),
    .wr    (ctl_wr),
    .wdata (ctl_wdata),
    .wipe  (wipe),
    .ctl_q (ctl_q)
  );

  wdt_respond u_resp (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .expire    (expire),
    .steer_rst (ctl_q[STEER]),
    .restart   (restart),
    .flag      (wdt_flag),
    .irq       (wdt_irq),
    .rst_req   (wdt_rst_req),
    .clr_stb   (ext_clr_stb)
  );

  assign ctl_rdata = ctl_q;

endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int RES_W = 2,
  parameter int MUL_W = 5,
  localparam int CTL_W = RES_W + MUL_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             ctl_wr,
  input logic [CTL_W-1:0] ctl_wdata,
  input logic             ctl_rd,
  input logic [CTL_W-1:0] ctl_rdata,
  input logic             wdt_flag,
  input logic             wdt_irq,
  input logic             wdt_rst_req,
  input logic             ext_clr_stb
);

  AST_NO_TICK_NO_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !ctl_wr && !ctl_rd) |=> !(wdt_irq || wdt_rst_req)); // R3

  AST_ZERO_MUL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && (ctl_wdata[RES_W +: MUL_W] == '0)) |=> !(wdt_irq || wdt_rst_req)); // R4

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_irq |=> !wdt_irq); // R5

  AST_IRQ_RST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wdt_irq && wdt_rst_req)); // R5

  AST_RST_WIPES_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |-> (ctl_rdata == '0 && ext_clr_stb)); // R6

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |=> !wdt_rst_req); // R6

  AST_EXPIRY_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_irq || wdt_rst_req) |-> wdt_flag); // R7

  AST_ACCESS_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr || ctl_rd) |=> !wdt_flag); // R7

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (ctl_rdata == $past(ctl_wdata))); // R10

endmodule

bind tick_watchdog wdt_chk #(.RES_W(RES_W), .MUL_W(MUL_W)) u_wdt_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .tick_en     (tick_en),
  .ctl_wr      (ctl_wr),
  .ctl_wdata   (ctl_wdata),
  .ctl_rd      (ctl_rd),
  .ctl_rdata   (ctl_rdata),
  .wdt_flag    (wdt_flag),
  .wdt_irq     (wdt_irq),
  .wdt_rst_req (wdt_rst_req),
  .ext_clr_stb (ext_clr_stb)
);

// File: tb/tick_watchdog_bench.sv
module tick_watchdog_bench;

  logic       clk;
  logic       rst_n;
  logic       tick_en;
  logic       ctl_wr;
  logic [7:0] ctl_wdata;
  logic       ctl_rd;
  logic [7:0] ctl_rdata;
  logic       wdt_flag, wdt_irq, wdt_rst_req, ext_clr_stb;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  tick_watchdog u_tick_watchdog (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rd(ctl_rd),
    .ctl_rdata(ctl_rdata), .wdt_flag(wdt_flag), .wdt_irq(wdt_irq),
    .wdt_rst_req(wdt_rst_req), .ext_clr_stb(ext_clr_stb)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Control byte and expected tick count (M x 4^R), steering bit clear.
  localparam int NV = 7;
  localparam logic [7:0] VEC_CTL [NV] = '{8'h04, 8'h05, 8'h06, 8'h0D, 8'h7C, 8'h07, 8'h7F};
  localparam int         VEC_N   [NV] = '{1, 4, 16, 12, 31, 64, 1984};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic rd();
    ctl_rd = 1'b1;
    @(negedge clk);
    ctl_rd = 1'b0;
  endtask

  task automatic tick();
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  // n ticks; returns 1 if any pulse was seen after any of them
  task automatic ticks_quiet(input int n, output bit seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (wdt_irq || wdt_rst_req || ext_clr_stb) seen = 1;
    end
  endtask

  initial begin
    bit seen;
    rst_n = 1'b0; tick_en = 1'b0; ctl_wr = 1'b0; ctl_rd = 1'b0; ctl_wdata = 8'h00;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    check(ctl_rdata == 8'h00, "R1 ctl", ctl_rdata, 0);
    check({wdt_flag, wdt_irq, wdt_rst_req, ext_clr_stb} == 4'b0, "R1 outputs",
          {wdt_flag, wdt_irq, wdt_rst_req, ext_clr_stb}, 0);

    // R2/R5/R9 table of intervals
    for (int v = 0; v < NV; v++) begin
      wr(VEC_CTL[v]);
      check(wdt_flag == 1'b0, "R7 flag clear after write", wdt_flag, 0);
      ticks_quiet(VEC_N[v] - 1, seen);
      check(!seen, "R2 no early timeout", seen, 0);
      tick();
      check(wdt_irq && !wdt_rst_req && wdt_flag, "R2 R5 timeout on last tick",
            {wdt_irq, wdt_rst_req, wdt_flag}, 3'b101);
      idle(1);
      check(!wdt_irq && wdt_flag, "R5 one-cycle pulse, R7 sticky flag",
            {wdt_irq, wdt_flag}, 2'b01);
      ticks_quiet(5, seen);
      check(!seen && wdt_flag, "R9 single timeout per arming", seen, 0);
    end

    // R3: no tick, no progress
    wr(8'h04);
    idle(40);
    check(!wdt_irq && !wdt_flag, "R3 idle without tick", wdt_flag, 0);
    tick();
    check(wdt_irq, "R3 tick then timeout", wdt_irq, 1);

    // R4: zero multiplier stays stopped
    wr(8'h00); ticks_quiet(300, seen);
    check(!seen && !wdt_flag, "R4 ctl 0x00 disabled", seen, 0);
    wr(8'h03); ticks_quiet(300, seen);
    check(!seen && !wdt_flag, "R4 ctl 0x03 disabled", seen, 0);
    wr(8'h80); ticks_quiet(300, seen);
    check(!seen && !wdt_flag, "R4 ctl 0x80 disabled", seen, 0);

    // R6: steered timeout
    wr(8'h85);
    ticks_quiet(3, seen);
    check(!seen && ctl_rdata == 8'h85, "R6 before timeout", ctl_rdata, 8'h85);
    tick();
    check(wdt_rst_req && ext_clr_stb && !wdt_irq && wdt_flag, "R6 reset request",
          {wdt_rst_req, ext_clr_stb, wdt_irq, wdt_flag}, 4'b1101);
    check(ctl_rdata == 8'h00, "R6 ctl wiped", ctl_rdata, 0);
    idle(1);
    check(!wdt_rst_req && !ext_clr_stb, "R6 one-cycle request",
          {wdt_rst_req, ext_clr_stb}, 0);
    rd(); ticks_quiet(100, seen);
    check(!seen, "R9 R6 wiped ctl stays stopped after read", seen, 0);

    // R7/R8: read clears flag and restarts without changing ctl
    wr(8'h04); tick();
    check(wdt_flag, "R7 flag set", wdt_flag, 1);
    rd();
    check(!wdt_flag && ctl_rdata == 8'h04, "R7 R8 read clears flag, keeps ctl",
          {wdt_flag, ctl_rdata}, 9'h004);
    tick();
    check(wdt_irq, "R8 read re-armed interval", wdt_irq, 1);

    wr(8'h05); ticks_quiet(3, seen);
    rd(); ticks_quiet(3, seen);
    check(!seen, "R8 read restarts full interval", seen, 0);
    tick();
    check(wdt_irq, "R8 timeout after restart", wdt_irq, 1);

    // R10: read on final tick cancels timeout
    wr(8'h05); ticks_quiet(3, seen);
    tick_en = 1'b1; ctl_rd = 1'b1;
    @(negedge clk);
    tick_en = 1'b0; ctl_rd = 1'b0;
    check(!wdt_irq && !wdt_flag, "R10 read beats final tick", wdt_irq, 0);
    ticks_quiet(3, seen);
    check(!seen, "R10 restarted count", seen, 0);
    tick();
    check(wdt_irq, "R10 timeout after cancelled one", wdt_irq, 1);

    // R10: write on final tick cancels and wins over read
    wr(8'h04);
    tick_en = 1'b1; ctl_wr = 1'b1; ctl_wdata = 8'h05; ctl_rd = 1'b1;
    @(negedge clk);
    tick_en = 1'b0; ctl_wr = 1'b0; ctl_rd = 1'b0;
    check(!wdt_irq && ctl_rdata == 8'h05, "R10 write beats read and tick",
          ctl_rdata, 8'h05);
    ticks_quiet(3, seen);
    tick();
    check(!seen && wdt_irq, "R10 written interval used", wdt_irq, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule